// File: doc/BRIEF.md
# Time-Aware Transmit Gate Scheduler

This block turns a stored gate control list into a per-queue transmit gate mask. Each list entry holds a gate pattern and the time it stays in force. The schedule is locked to a seconds/nanoseconds time-of-day input. Once enabled, the block keeps every gate open until the current time, plus a small offset for clock-domain delay, reaches a programmed base time. It then walks the list entry by entry, one cycle after another.

The list lives in an external memory that has two banks. A separate access port loads that memory. This block only reads it, over an asynchronous read port: the data for `mem_addr_o` is expected back in the same clock. Software may fill the bank that is not in use while a schedule runs, and then ask for a bank switch. The switch is applied only at the start of a cycle. Gate bit 0 can also be sent out as a hold/release request for frame preemption.

Time inside an entry and inside a cycle is counted in nanoseconds. The count advances by `NS_PER_CLK` for each clock.

Top module: `tas_gate_sched`

## Requirements
- R1: After reset, `gate_o` is all ones, and `hold_o`, `run_o` and `bank_o` are 0.
- R2: While enabled but not yet started, all gates stay open. In the clock after an edge where the adjusted time is at or past the base time, `run_o` is 1 and entry 0 is in force. The adjusted time is `tod` plus `ofs_ns_i` nanoseconds. Base time is compared as seconds first, then nanoseconds.
- R3: An entry is 32 bits. Bits [IVL_W-1:0] hold the interval in ns, and bits [31:IVL_W] hold the gate mask driven on `gate_o`. An entry with interval I stays in force for ceil(I/NS_PER_CLK) clocks, then the next entry follows.
- R4: An entry with interval 0 stays in force for exactly one clock, so the sequence never stalls.
- R5: After the entry with index `list_len_i`-1, the sequence restarts at entry 0. It also restarts after index DEPTH-1. A length of 0 behaves as a length of 1.
- R6: When the cycle time (seconds*1e9 + ns) has elapsed, that is after max(1, ceil(cycle/NS_PER_CLK)) clocks, entry 0 restarts. This happens even if the list has not finished.
- R7: A one-clock `sw_req_i` pulse is held until the next cycle start, including the first start after enable. At that point `bank_o` toggles. The read address is {bank, index}, with the bank in the MSB.
- R8: With `fp_mode_i` = 1, `hold_o` equals gate bit 0 (entry bit IVL_W) of the entry in force: 1 means hold, 0 means release. With `fp_mode_i` = 0, `hold_o` stays 0.
- R9: In the clock after an edge with `en_i` = 0, `run_o` is 0 and all gates are open. The bank and any pending switch are kept.
- R10: Adding the offset carries into the seconds when the nanoseconds overflow 999,999,999.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Schedule enable |
| sw_req_i | input | 1 | Pulse: switch to the other list bank at the next cycle start |
| fp_mode_i | input | 1 | Drive gate bit 0 as the preemption hold/release request |
| ofs_ns_i | input | 8 | Clock-domain delay compensation, in ns |
| tod_sec_i | input | 32 | Current time, seconds |
| tod_ns_i | input | 32 | Current time, nanoseconds (below 1e9) |
| base_sec_i | input | 32 | Schedule start, seconds |
| base_ns_i | input | 32 | Schedule start, nanoseconds |
| cyc_sec_i | input | 32 | Cycle time, whole seconds |
| cyc_ns_i | input | 32 | Cycle time, sub-second nanoseconds |
| list_len_i | input | LEN_W (7) | Number of entries in use |
| mem_addr_o | output | IDX_W+1 (7) | List read address {bank, index} |
| mem_data_i | input | 32 | List entry at `mem_addr_o` (same-clock read) |
| gate_o | output | GATE_W (8) | Per-queue gate mask, 1 = open |
| hold_o | output | 1 | Preemption hold request |
| run_o | output | 1 | Schedule executing |
| bank_o | output | 1 | List bank in use |

## Verification
If the entry index or the in-entry timer is wrong, the gate pattern of the wrong entry reaches `gate_o` in the same clock, and it stays wrong on every later entry boundary. A cycle counter that is off moves the restart to entry 0 by at least one clock, which shows as a gate pattern that does not match. A wrong bank or a lost switch request shows as a toggle of `bank_o` at the wrong cycle start, and as patterns read from the other bank. The bench compares `gate_o`, `hold_o`, `run_o` and `bank_o` against its own per-clock model on every clock. Any of these faults is therefore reported in the clock where it first becomes visible.

// File: rtl/tas_pkg.sv
`timescale 1ns/1ps
package tas_pkg;
    localparam int ENTRY_W = 32;
    localparam logic [63:0] NSEC_PER_SEC = 64'd1_000_000_000;
endpackage

// File: rtl/tas_start_cmp.sv
`timescale 1ns/1ps
module tas_start_cmp (
    input  logic [31:0] tod_sec_i,
    input  logic [31:0] tod_ns_i,
    input  logic [7:0]  ofs_ns_i,
    input  logic [31:0] base_sec_i,
    input  logic [31:0] base_ns_i,
    output logic        reached_o
);
    localparam logic [32:0] NS_WRAP = 33'(tas_pkg::NSEC_PER_SEC);

    logic [32:0] ns_sum;
    logic        carry;
    logic [32:0] adj_ns;
    logic [32:0] adj_sec;

    always_comb begin
        ns_sum  = {1'b0, tod_ns_i} + {25'b0, ofs_ns_i};
        carry   = (ns_sum >= NS_WRAP);
        adj_ns  = carry ? (ns_sum - NS_WRAP) : ns_sum;
        adj_sec = {1'b0, tod_sec_i} + {32'b0, carry};
        reached_o = (adj_sec > {1'b0, base_sec_i}) ||
                    ((adj_sec == {1'b0, base_sec_i}) && (adj_ns >= {1'b0, base_ns_i}));
    end
endmodule

// File: rtl/tas_entry_seq.sv
`timescale 1ns/1ps
module tas_entry_seq #(
    parameter int IVL_W      = 24,
    parameter int DEPTH      = 64,
    parameter int NS_PER_CLK = 5,
    localparam int IDX_W     = $clog2(DEPTH),
    localparam int LEN_W     = IDX_W + 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             sw_req_i,
    input  logic             reached_i,
    input  logic [IVL_W-1:0] ivl_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [63:0]      cyc_total_i,
    output logic             run_o,
    output logic             bank_o,
    output logic [IDX_W-1:0] idx_o
);
    typedef struct packed {
        logic             run;
        logic             bank;
        logic             pend;
        logic [IDX_W-1:0] idx;
        logic [31:0]      ent_ns;
        logic [63:0]      cyc_ns;
    } seq_t;

    seq_t seq_d, seq_q;

    logic        pend_eff;
    logic [31:0] ent_nx;
    logic [63:0] cyc_nx;
    logic        ent_done, last_ent, cyc_done, boundary;

    always_comb begin
        seq_d    = seq_q;
        pend_eff = seq_q.pend | sw_req_i;
        ent_nx   = seq_q.ent_ns + 32'(NS_PER_CLK);
        cyc_nx   = seq_q.cyc_ns + 64'(NS_PER_CLK);
        ent_done = (ent_nx >= 32'(ivl_i));
        last_ent = (({1'b0, seq_q.idx} + LEN_W'(1)) >= len_i) ||
                   (seq_q.idx == IDX_W'(DEPTH - 1));
        cyc_done = (cyc_nx >= cyc_total_i);
        boundary = 1'b0;
        seq_d.pend = pend_eff;

        if (!en_i) begin
            seq_d.run = 1'b0;
        end else if (!seq_q.run) begin
            if (reached_i) begin
                seq_d.run = 1'b1;
                boundary  = 1'b1;
            end
        end else if (cyc_done || (ent_done && last_ent)) begin
            boundary = 1'b1;
        end else if (ent_done) begin
            seq_d.idx    = seq_q.idx + IDX_W'(1);
            seq_d.ent_ns = '0;
            seq_d.cyc_ns = cyc_nx;
        end else begin
            seq_d.ent_ns = ent_nx;
            seq_d.cyc_ns = cyc_nx;
        end

        if (boundary) begin
            seq_d.idx    = '0;
            seq_d.ent_ns = '0;
            seq_d.cyc_ns = '0;
            seq_d.bank   = seq_q.bank ^ pend_eff;
            seq_d.pend   = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) seq_q <= '0;
        else         seq_q <= seq_d;
    end

    assign run_o  = seq_q.run;
    assign bank_o = seq_q.bank;
    assign idx_o  = seq_q.idx;

    assert_entry_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_q.run && seq_q.ent_ns != '0) |->
            (seq_q.ent_ns == $past(seq_q.ent_ns) + 32'(NS_PER_CLK)) && (seq_q.idx == $past(seq_q.idx)));

    assert_cycle_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_q.run && seq_q.cyc_ns != '0) |->
            (seq_q.cyc_ns == $past(seq_q.cyc_ns) + 64'(NS_PER_CLK)));

    assert_bank_at_boundary_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_q.bank != $past(seq_q.bank)) |->
            (seq_q.run && seq_q.idx == '0 && seq_q.cyc_ns == '0 && !seq_q.pend));
endmodule

// File: rtl/tas_gate_sched.sv
`timescale 1ns/1ps
module tas_gate_sched #(
    parameter int IVL_W      = 24,
    parameter int DEPTH      = 64,
    parameter int NS_PER_CLK = 5,
    localparam int GATE_W    = tas_pkg::ENTRY_W - IVL_W,
    localparam int IDX_W     = $clog2(DEPTH),
    localparam int LEN_W     = IDX_W + 1
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        en_i,
    input  logic                        sw_req_i,
    input  logic                        fp_mode_i,
    input  logic [7:0]                  ofs_ns_i,
    input  logic [31:0]                 tod_sec_i,
    input  logic [31:0]                 tod_ns_i,
    input  logic [31:0]                 base_sec_i,
    input  logic [31:0]                 base_ns_i,
    input  logic [31:0]                 cyc_sec_i,
    input  logic [31:0]                 cyc_ns_i,
    input  logic [LEN_W-1:0]            list_len_i,
    output logic [IDX_W:0]              mem_addr_o,
    input  logic [tas_pkg::ENTRY_W-1:0] mem_data_i,
    output logic [GATE_W-1:0]           gate_o,
    output logic                        hold_o,
    output logic                        run_o,
    output logic                        bank_o
);
    logic             reached;
    logic [63:0]      cyc_total;
    logic [IDX_W-1:0] idx;
    logic             run, bank;

    assign cyc_total = ({32'b0, cyc_sec_i} * tas_pkg::NSEC_PER_SEC) + {32'b0, cyc_ns_i};

    tas_start_cmp u_start_cmp (
        .tod_sec_i  (tod_sec_i),
        .tod_ns_i   (tod_ns_i),
        .ofs_ns_i   (ofs_ns_i),
        .base_sec_i (base_sec_i),
        .base_ns_i  (base_ns_i),
        .reached_o  (reached)
    );

    tas_entry_seq #(
        .IVL_W      (IVL_W),
        .DEPTH      (DEPTH),
        .NS_PER_CLK (NS_PER_CLK)
    ) u_entry_seq (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .en_i        (en_i),
        .sw_req_i    (sw_req_i),
        .reached_i   (reached),
        .ivl_i       (mem_data_i[IVL_W-1:0]),
        .len_i       (list_len_i),
        .cyc_total_i (cyc_total),
        .run_o       (run),
        .bank_o      (bank),
        .idx_o       (idx)
    );

    assign mem_addr_o = {bank, idx};
    assign gate_o     = run ? mem_data_i[tas_pkg::ENTRY_W-1:IVL_W] : '1;
    assign hold_o     = run & fp_mode_i & mem_data_i[IVL_W];
    assign run_o      = run;
    assign bank_o     = bank;

    assert_start_at_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(run_o) |-> (mem_addr_o[IDX_W-1:0] == '0));

    assert_disable_opens_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(en_i) |-> (!run_o && gate_o == '1 && !hold_o));
endmodule

// File: tb/tas_gate_sched_bench.sv
`timescale 1ns/1ps
module tas_gate_sched_bench;
    localparam int W = 24;
    localparam int DEPTH = 64;
    localparam int NS = 5;
    localparam int GW = 32 - W;
    localparam int IW = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, sw_req = 1'b0, fp = 1'b0;
    logic [7:0] ofs = '0;
    logic [31:0] tod_sec = 32'd5, tod_ns = 32'd0;
    logic [31:0] base_sec = '0, base_ns = '0, cyc_sec = 32'd1, cyc_ns = '0;
    logic [IW:0] len = 7'd4;
    logic [IW:0] mem_addr;
    logic [31:0] mem_data;
    logic [GW-1:0] gate;
    logic hold, run, bank;
    logic [31:0] mem [0:2*DEPTH-1];

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    bit m_run = 0, m_bank = 0, m_pend = 0;
    int m_idx = 0;
    longint m_ent = 0, m_cyc = 0;

    always #2.5 clk = ~clk;
    assign mem_data = mem[mem_addr];

    tas_gate_sched #(.IVL_W(W), .DEPTH(DEPTH), .NS_PER_CLK(NS)) u_tas_gate_sched (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en), .sw_req_i(sw_req), .fp_mode_i(fp),
        .ofs_ns_i(ofs), .tod_sec_i(tod_sec), .tod_ns_i(tod_ns),
        .base_sec_i(base_sec), .base_ns_i(base_ns), .cyc_sec_i(cyc_sec), .cyc_ns_i(cyc_ns),
        .list_len_i(len), .mem_addr_o(mem_addr), .mem_data_i(mem_data),
        .gate_o(gate), .hold_o(hold), .run_o(run), .bank_o(bank));

    function automatic longint dur(logic [31:0] e);
        longint iv = longint'(e[W-1:0]);
        return (iv == 0) ? 1 : (iv + NS - 1) / NS;
    endfunction

    function automatic longint cyc_clks();
        longint t = longint'(cyc_sec) * 1000000000 + longint'(cyc_ns);
        longint c = (t + NS - 1) / NS;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic bit reach(logic [31:0] s, logic [31:0] n);
        longint a = longint'(s) * 1000000000 + longint'(n) + longint'(ofs);
        longint b = longint'(base_sec) * 1000000000 + longint'(base_ns);
        return a >= b;
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic check_all(input string tag);
        logic [31:0] e = mem[{m_bank, IW'(m_idx)}];
        chk(tag, "gate", 32'(gate), m_run ? 32'(e[31:W]) : 32'((1 << GW) - 1));
        chk(tag, "hold", 32'(hold), 32'(m_run & fp & e[W]));
        chk(tag, "run", 32'(run), 32'(m_run));
        chk(tag, "bank", 32'(bank), 32'(m_bank));
    endtask

    task automatic new_cycle(input bit pe);
        m_idx = 0; m_ent = 0; m_cyc = 0;
        m_bank = m_bank ^ pe; m_pend = 0;
    endtask

    task automatic tick();
        logic [31:0] ps = tod_sec, pn = tod_ns;
        bit pen = en, psw = sw_req;
        bit pe, edone, last;
        @(posedge clk); #1;
        pe = m_pend | psw;
        m_pend = pe;
        if (!pen) m_run = 0;
        else if (!m_run) begin
            if (reach(ps, pn)) begin m_run = 1; new_cycle(pe); end
        end else begin
            m_ent++; m_cyc++;
            edone = m_ent >= dur(mem[{m_bank, IW'(m_idx)}]);
            last = (m_idx + 1 >= int'(len)) || (m_idx == DEPTH - 1);
            if (m_cyc >= cyc_clks() || (edone && last)) new_cycle(pe);
            else if (edone) begin m_idx++; m_ent = 0; end
        end
        sw_req = 1'b0;
        tod_ns = tod_ns + NS;
        if (tod_ns >= 32'd1_000_000_000) begin tod_ns = tod_ns - 32'd1_000_000_000; tod_sec++; end
    endtask

    task automatic run_for(input string tag, input int n);
        for (int i = 0; i < n; i++) begin tick(); check_all(tag); end
    endtask

    task automatic fill(input bit b, input int maxivl, input bit zeros);
        for (int i = 0; i < DEPTH; i++) begin
            int iv = 1 + int'($urandom % maxivl);
            if (zeros && ($urandom % 3 == 0)) iv = 0;
            mem[b * DEPTH + i] = {GW'($urandom), W'(iv)};
        end
    endtask

    task automatic restart(input string tag);
        en = 1'b0; tick(); check_all(tag);
        base_sec = tod_sec; base_ns = tod_ns;
        en = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd4242));
        fill(0, 40, 0); fill(1, 40, 0);
        repeat (3) @(posedge clk);
        #1; rst_n = 1'b1;
        // R1: reset state
        check_all("R1");
        chk("R1", "reset gate", 32'(gate), 32'hFF);
        run_for("R1", 3);

        // R10: offset pushes nanoseconds over the second boundary
        tod_sec = 32'd5; tod_ns = 32'd999_999_800; ofs = 8'd60;
        base_sec = 32'd6; base_ns = 32'd20; len = 7'd4;
        en = 1'b1;
        run_for("R10", 30);
        chk("R10", "still waiting", 32'(run), 32'd0);
        run_for("R10", 15);
        chk("R10", "started", 32'(run), 32'd1);

        // R2: start aligned to base time, gates open before
        en = 1'b0; tick(); check_all("R2");
        ofs = 8'd0; base_sec = tod_sec; base_ns = tod_ns + 32'd200;
        en = 1'b1;
        run_for("R2", 60);

        // R3: random intervals, long cycle
        fill(m_bank, 60, 0); len = 7'd6; cyc_sec = 32'd1; cyc_ns = 32'd0;
        restart("R3"); run_for("R3", 150);

        // R4: zero-length entries
        fill(m_bank, 30, 1); mem[m_bank * DEPTH + 1][W-1:0] = '0;
        restart("R4"); run_for("R4", 80);

        // R5: wrap at list length, then length 0
        fill(m_bank, 20, 0); len = 7'd3;
        restart("R5"); run_for("R5", 80);
        len = 7'd0; restart("R5"); run_for("R5", 20);

        // R6: cycle shorter than the list, not a multiple of the step
        fill(m_bank, 60, 0); len = 7'd8; cyc_sec = 32'd0; cyc_ns = 32'd97;
        restart("R6"); run_for("R6", 100);
        cyc_ns = 32'd0; restart("R6"); run_for("R6", 10);

        // R7: bank switch at cycle boundary
        cyc_sec = 32'd0; cyc_ns = 32'd400; len = 7'd4;
        restart("R7"); run_for("R7", 17);
        fill(!m_bank, 40, 0); sw_req = 1'b1;
        run_for("R7", 100);
        sw_req = 1'b1; run_for("R7", 100);

        // R8: preemption hold output
        fp = 1'b1; fill(m_bank, 30, 0); restart("R8"); run_for("R8", 80);
        fp = 1'b0; run_for("R8", 20);

        // R9: disable mid-run, pending switch kept
        en = 1'b1; run_for("R9", 7);
        sw_req = 1'b1; tick(); check_all("R9");
        en = 1'b0; run_for("R9", 5);
        chk("R9", "gates open", 32'(gate), 32'hFF);

        // random mix (checked as R3 timing)
        for (int r = 0; r < 8; r++) begin
            fill(0, 50, 1); fill(1, 50, 1);
            len = 7'(1 + $urandom % 8);
            cyc_sec = 32'd0; cyc_ns = 32'(20 + $urandom % 600);
            fp = 1'($urandom);
            restart("R3");
            for (int k = 0; k < 120; k++) begin
                if ($urandom % 40 == 0) sw_req = 1'b1;
                tick(); check_all("R3");
            end
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule